// File: doc/BRIEF.md
# Security Attribution Region Checker

This block decides, for any 32-bit address, which of three security classes it belongs to: Secure, Non-Secure Callable (a gateway class that Non-Secure code may branch into but not read or write), or Non-Secure. Secure software programs a small bank of region descriptors. Each descriptor has a base granule, a limit granule, a callable flag and an enable bit. A global enable bit then switches the unit on. Any address that no enabled region covers is Secure.

A lookup port takes an address, the security state of the requester and the kind of access (data or instruction fetch). It returns the attribution in the same cycle. The attribution is merged with an external, tie-off attribution input, and the more secure of the two is used. A Non-Secure access that breaks the rules raises a fault flag one cycle later. The first such violation is captured in a fault status register together with its address and access kind, and it stays there until Secure software clears it.

All control and status registers are reachable only from Secure state. Non-Secure writes change nothing, and Non-Secure reads return zero.

Top module: `sec_attr_checker`

## Requirements
- R1: After reset the global enable is 0, every region is disabled, the fault status reads 0, `lk_fault` is 0, and every lookup returns Secure (code 2'b00) when `ext_attr` allows it.
- R2: Register select codes are 0 = control (bit 0 is the global enable), 1 = index, 2 = base, 3 = limit, 4 = fault status, 5 = fault address. Base and limit writes go to the region chosen by the index register. Address bits [4:0] of the base and limit are dropped. Base reads back as {granule, 5'b0}. Limit reads back as {granule, 3'b0, callable bit 1, enable bit 0}.
- R3: A register write with `reg_secure`=0 changes no register, including the fault status. A register read with `reg_secure`=0 returns zero.
- R4: An enabled region matches when base <= addr[31:5] <= limit, inclusive at both ends. A single match gives Non-Secure Callable (2'b01) if the callable bit is set, and Non-Secure (2'b10) otherwise.
- R5: An address matched by no enabled region is Secure. While the global enable is 0, every address is Secure. A disabled region never matches.
- R6: An address matched by two or more enabled regions is Secure.
- R7: The result is the more secure of the region result and `ext_attr`. The order is Secure > Callable > Non-Secure. The `ext_attr` code 2'b11 counts as Non-Secure.
- R8: A Non-Secure data access to a Secure or Callable address is a violation. A Non-Secure data access to a Non-Secure address is not. A Secure requester never causes a violation.
- R9: A Non-Secure instruction fetch to a Secure address is a violation. A Non-Secure fetch to a Callable or Non-Secure address is not.
- R10: `lk_fault` is high in the cycle after a valid lookup that violates the rules, and low otherwise. The fault status latches the first violation: bit 0 is valid, bit 1 is set for a fetch, and the fault address register holds the address. Later violations do not overwrite it. A Secure write of 1 to status bit 0 clears it. A violation in that same cycle is latched instead of being cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_secure | input | 1 | Security state of the register requester (1 = Secure) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 32 | Lookup address |
| lk_secure | input | 1 | Security state of the lookup requester (1 = Secure) |
| lk_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| ext_attr | input | 2 | External attribution for `lk_addr` |
| lk_attr | output | 2 | Attribution: 00 Secure, 01 Callable, 10 Non-Secure |
| lk_fault | output | 1 | Registered security violation flag |

## Verification
Every 32-byte granule of the low 2 KB is swept at both its first and last byte. The bench uses a region layout that contains a callable region, two overlapping regions, a one-granule region and a disabled region. The sweep therefore separates off-by-one limit errors, wrong overlap handling and a disabled region that still matches.

Each address is looked up as a Secure and a Non-Secure requester, and as both data and fetch. This separates the data rule from the fetch rule at callable addresses. The `ext_attr` codes are swept over the three region classes to confirm the more-secure merge. The top granule of the address space is also checked for a 27-bit compare that has been truncated.

Fault capture is checked with a pair of back-to-back violations, which exposes a status register that overwrites the first violation. Non-Secure clear attempts and Non-Secure reads are checked the same way, at the register ports.

// File: rtl/sac_pkg.sv
// Shared codes for the security attribution checker.
// Attribution codes are ordered so that a smaller value is more secure.
package sac_pkg;
    localparam logic [1:0] ATTR_S   = 2'b00;
    localparam logic [1:0] ATTR_NSC = 2'b01;
    localparam logic [1:0] ATTR_NS  = 2'b10;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_INDEX = 3'd1;
    localparam logic [2:0] SEL_BASE  = 3'd2;
    localparam logic [2:0] SEL_LIMIT = 3'd3;
    localparam logic [2:0] SEL_FSTAT = 3'd4;
    localparam logic [2:0] SEL_FADDR = 3'd5;

    localparam int LIM_EN_BIT  = 0;
    localparam int LIM_NSC_BIT = 1;

    // Returns the more secure of two attribution codes; 2'b11 counts as NS.
    function automatic logic [1:0] more_secure(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] bb;
        bb = (b == 2'b11) ? ATTR_NS : b;
        return (a < bb) ? a : bb;
    endfunction
endpackage

// File: rtl/sac_regbank.sv
// Register bank: control enable, region index, per-region base/limit/flags,
// and the read view of the fault status. Only Secure requesters may write or
// read; Non-Secure writes are dropped and Non-Secure reads return zero.
// Assumes GRAN_BITS >= 2 so the limit flags fit below the granule field.
module sac_regbank
    import sac_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 5,
    localparam int GW         = ADDR_W - GRAN_BITS,
    localparam int IDXW       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic                          reg_secure,
    input  logic [2:0]                    reg_sel,
    input  logic [ADDR_W-1:0]             reg_wdata,
    input  logic                          flt_valid,
    input  logic                          flt_fetch,
    input  logic [ADDR_W-1:0]             flt_addr,
    output logic [ADDR_W-1:0]             reg_rdata,
    output logic                          ctrl_en,
    output logic [NUM_REGIONS-1:0][GW-1:0] base_o,
    output logic [NUM_REGIONS-1:0][GW-1:0] lim_o,
    output logic [NUM_REGIONS-1:0]        nsc_o,
    output logic [NUM_REGIONS-1:0]        en_o,
    output logic                          flt_clr
);
    logic [IDXW-1:0] idx_q;
    logic            idx_ok;
    logic            sec_wr;

    assign sec_wr  = reg_wr && reg_secure;
    assign idx_ok  = (int'(idx_q) < NUM_REGIONS);
    assign flt_clr = sec_wr && (reg_sel == SEL_FSTAT) && reg_wdata[0];

    // Secure register writes update control, index and the selected region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            idx_q   <= '0;
            base_o  <= '0;
            lim_o   <= '0;
            nsc_o   <= '0;
            en_o    <= '0;
        end else if (sec_wr) begin
            case (reg_sel)
                SEL_CTRL:  ctrl_en <= reg_wdata[0];
                SEL_INDEX: idx_q   <= reg_wdata[IDXW-1:0];
                SEL_BASE:  if (idx_ok) base_o[idx_q] <= reg_wdata[ADDR_W-1:GRAN_BITS];
                SEL_LIMIT: if (idx_ok) begin
                    lim_o[idx_q] <= reg_wdata[ADDR_W-1:GRAN_BITS];
                    nsc_o[idx_q] <= reg_wdata[LIM_NSC_BIT];
                    en_o[idx_q]  <= reg_wdata[LIM_EN_BIT];
                end
                default: ;
            endcase
        end
    end

    // Read mux, gated to zero for Non-Secure or idle reads.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd && reg_secure) begin
            case (reg_sel)
                SEL_CTRL:  reg_rdata[0] = ctrl_en;
                SEL_INDEX: reg_rdata[IDXW-1:0] = idx_q;
                SEL_BASE:  if (idx_ok) reg_rdata = {base_o[idx_q], {GRAN_BITS{1'b0}}};
                SEL_LIMIT: if (idx_ok) reg_rdata = {lim_o[idx_q], {(GRAN_BITS-2){1'b0}},
                                                    nsc_o[idx_q], en_o[idx_q]};
                SEL_FSTAT: reg_rdata[1:0] = {flt_fetch, flt_valid};
                SEL_FADDR: reg_rdata = flt_addr;
                default:   reg_rdata = '0;
            endcase
        end
    end

    AST_NS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_secure) |=> ($stable(ctrl_en) && $stable(idx_q) && $stable(en_o))) // R3
        else $error("NS write changed a register");
endmodule

// File: rtl/sac_region_cmp.sv
// One region comparator: reports a hit when the region is enabled and the
// address granule lies between base and limit, both ends inclusive.
module sac_region_cmp #(
    parameter int GW = 27
) (
    input  logic [GW-1:0] addr_g,
    input  logic [GW-1:0] base,
    input  logic [GW-1:0] limit,
    input  logic          en,
    output logic          hit
);
    // Inclusive window compare.
    always_comb hit = en && (addr_g >= base) && (addr_g <= limit);
endmodule

// File: rtl/sac_fault_cap.sv
// Fault capture: registers the per-lookup violation flag and holds the first
// violation (address, access kind) until a Secure clear. A violation arriving
// together with a clear is latched.
module sac_fault_cap #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              viol,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_fetch,
    input  logic              clr,
    output logic              fault_q,
    output logic              flt_valid,
    output logic              flt_fetch,
    output logic [ADDR_W-1:0] flt_addr
);
    logic new_flt;
    assign new_flt = lk_valid && viol;

    // One-cycle fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= new_flt;
    end

    // First-violation status capture with Secure clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_valid <= 1'b0;
            flt_fetch <= 1'b0;
            flt_addr  <= '0;
        end else if (new_flt && (!flt_valid || clr)) begin
            flt_valid <= 1'b1;
            flt_fetch <= lk_fetch;
            flt_addr  <= lk_addr;
        end else if (clr) begin
            flt_valid <= 1'b0;
            flt_fetch <= 1'b0;
            flt_addr  <= '0;
        end
    end

    AST_FLAG_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && viol) |=> fault_q) // R10
        else $error("fault flag missing");
    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !clr) |=> (flt_valid && $stable(flt_addr) && $stable(flt_fetch))) // R10
        else $error("first violation overwritten");
endmodule

// File: rtl/sec_attr_checker.sv
// Top of the security attribution checker. Combines the region comparators
// into a three-way attribution, merges the external attribution, derives the
// Non-Secure access violation, and hands it to the fault capture stage.
// Assumes the external attribution input is valid with lk_addr.
module sec_attr_checker
    import sac_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 5,
    localparam int GW         = ADDR_W - GRAN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_secure,
    input  logic [2:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_secure,
    input  logic              lk_fetch,
    input  logic [1:0]        ext_attr,
    output logic [1:0]        lk_attr,
    output logic              lk_fault
);
    logic                           ctrl_en;
    logic [NUM_REGIONS-1:0][GW-1:0] base_w;
    logic [NUM_REGIONS-1:0][GW-1:0] lim_w;
    logic [NUM_REGIONS-1:0]         nsc_w;
    logic [NUM_REGIONS-1:0]         en_w;
    logic [NUM_REGIONS-1:0]         hit;
    logic                           flt_clr;
    logic                           flt_valid;
    logic                           flt_fetch;
    logic [ADDR_W-1:0]              flt_addr;
    logic [1:0]                     region_attr;
    logic                           viol;

    sac_regbank #(
        .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_secure(reg_secure), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .flt_valid(flt_valid), .flt_fetch(flt_fetch), .flt_addr(flt_addr),
        .reg_rdata(reg_rdata), .ctrl_en(ctrl_en), .base_o(base_w),
        .lim_o(lim_w), .nsc_o(nsc_w), .en_o(en_w), .flt_clr(flt_clr)
    );

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        sac_region_cmp #(.GW(GW)) u_cmp (
            .addr_g(lk_addr[ADDR_W-1:GRAN_BITS]), .base(base_w[i]),
            .limit(lim_w[i]), .en(en_w[i]), .hit(hit[i])
        );
    end

    // Region attribution: single hit decides, none or several give Secure.
    always_comb begin
        if (!ctrl_en || ($countones(hit) != 1))
            region_attr = ATTR_S;
        else if (|(hit & nsc_w))
            region_attr = ATTR_NSC;
        else
            region_attr = ATTR_NS;
    end

    // Final attribution: the more secure of region and external inputs.
    assign lk_attr = more_secure(region_attr, ext_attr);

    // Non-Secure access rule: data needs NS, fetch needs NS or Callable.
    always_comb begin
        if (lk_secure)     viol = 1'b0;
        else if (lk_fetch) viol = (lk_attr == ATTR_S);
        else               viol = (lk_attr != ATTR_NS);
    end

    sac_fault_cap #(.ADDR_W(ADDR_W)) u_fault (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .viol(viol),
        .lk_addr(lk_addr), .lk_fetch(lk_fetch), .clr(flt_clr),
        .fault_q(lk_fault), .flt_valid(flt_valid), .flt_fetch(flt_fetch),
        .flt_addr(flt_addr)
    );

    AST_DISABLED_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (region_attr == ATTR_S)) // R5
        else $error("attribution not Secure while disabled");
    AST_SECURE_REQ_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_secure) |=> !lk_fault) // R8
        else $error("Secure requester faulted");
    AST_FETCH_NSC_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_secure && lk_fetch && (lk_attr == ATTR_NSC)) |=> !lk_fault) // R9
        else $error("fetch into callable faulted");
endmodule

// File: tb/sec_attr_checker_test.sv
// Self-checking bench: programs a small region layout and sweeps addresses,
// requester states, access kinds and external codes against a bench model.
module sec_attr_checker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_secure = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0, lk_secure = 1'b0, lk_fetch = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [1:0]  ext_attr = 2'b10;
    logic [1:0]  lk_attr;
    logic        lk_fault;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Bench model of the programmed configuration.
    logic [26:0] mb [8];
    logic [26:0] ml [8];
    bit          mn [8];
    bit          me [8];
    bit          mctrl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_attr_checker uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_secure(reg_secure), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_secure(lk_secure), .lk_fetch(lk_fetch), .ext_attr(ext_attr),
        .lk_attr(lk_attr), .lk_fault(lk_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d, input bit sec);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; reg_secure = sec;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] sel, input bit sec,
                          input logic [31:0] exp);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = sel; reg_secure = sec;
        #1;
        chk(req, reg_rdata, exp);
        reg_rd = 1'b0;
    endtask

    task automatic prog(input int i, input logic [26:0] b, input logic [26:0] l,
                        input bit nsc, input bit en);
        wr(3'd1, i, 1'b1);
        wr(3'd2, {b, 5'h1F}, 1'b1);   // R2: low bits must be dropped
        wr(3'd3, {l, 3'b111, nsc, en}, 1'b1);
        mb[i] = b; ml[i] = l; mn[i] = nsc; me[i] = en;
    endtask

    function automatic logic [1:0] exp_attr(input logic [31:0] a, input logic [1:0] e);
        logic [1:0] r, ee;
        int cnt;
        bit cal;
        cnt = 0; cal = 0;
        for (int i = 0; i < 8; i++)
            if (me[i] && a[31:5] >= mb[i] && a[31:5] <= ml[i]) begin
                cnt++; cal = mn[i];
            end
        if (!mctrl || cnt != 1) r = 2'b00;
        else                    r = cal ? 2'b01 : 2'b10;
        ee = (e == 2'b11) ? 2'b10 : e;
        return (r < ee) ? r : ee;
    endfunction

    // One lookup: checks attribution now and the fault flag one cycle later.
    task automatic look(input string req, input logic [31:0] a, input bit sec,
                        input bit fetch, input logic [1:0] e);
        logic [1:0] x;
        bit f;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_secure = sec; lk_fetch = fetch; ext_attr = e;
        x = exp_attr(a, e);
        f = !sec && (fetch ? (x == 2'b00) : (x != 2'b10));
        #1;
        chk({req, " attr"}, {30'b0, lk_attr}, {30'b0, x});
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " fault R10"}, {31'b0, lk_fault}, {31'b0, f});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin mb[i] = '0; ml[i] = '0; mn[i] = 0; me[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1 ctrl", 3'd0, 1'b1, 32'h0);
        rd_chk("R1 limit0", 3'd3, 1'b1, 32'h0);
        rd_chk("R1 fstat", 3'd4, 1'b1, 32'h0);
        chk("R1 fault", {31'b0, lk_fault}, 32'h0);
        look("R1 lookup", 32'h0000_0100, 1'b0, 1'b0, 2'b10);

        // R2: program layout, read back
        prog(0, 27'd4,  27'd7,  1, 1);
        prog(1, 27'd10, 27'd20, 0, 1);
        prog(2, 27'd18, 27'd25, 0, 1);   // overlaps region 1 on 18..20
        prog(3, 27'd30, 27'd30, 0, 1);   // single granule
        prog(4, 27'd40, 27'd50, 0, 0);   // disabled
        prog(7, 27'h7FF_FFFF, 27'h7FF_FFFF, 0, 1);
        wr(3'd1, 32'd0, 1'b1);
        rd_chk("R2 index", 3'd1, 1'b1, 32'd0);
        rd_chk("R2 base0", 3'd2, 1'b1, 32'h80);
        rd_chk("R2 limit0", 3'd3, 1'b1, {27'd7, 5'b00011});
        wr(3'd1, 32'd4, 1'b1);
        rd_chk("R2 limit4", 3'd3, 1'b1, {27'd50, 5'b00000});

        // R5: global enable off, all Secure
        for (int g = 0; g < 32; g++) look("R5 disabled", {g[26:0], 5'd0}, 1'b0, 1'b0, 2'b10);

        // R3: Non-Secure register access
        wr(3'd0, 32'h1, 1'b0);
        rd_chk("R3 ctrl unchanged", 3'd0, 1'b1, 32'h0);
        rd_chk("R3 NS read zero", 3'd2, 1'b0, 32'h0);
        wr(3'd1, 32'd1, 1'b0);
        rd_chk("R3 index unchanged", 3'd1, 1'b1, 32'd4);

        wr(3'd0, 32'h1, 1'b1);
        mctrl = 1;
        rd_chk("R2 ctrl", 3'd0, 1'b1, 32'h1);

        // R4 R5 R6 R8 R9: granule sweep of the low 2 KB
        for (int g = 0; g < 64; g++)
            for (int o = 0; o < 2; o++)
                for (int s = 0; s < 2; s++)
                    for (int f = 0; f < 2; f++)
                        look("R4 R6 R8 R9 sweep", {g[26:0], (o == 1) ? 5'h1F : 5'h00},
                             s[0], f[0], 2'b10);
        look("R4 top", 32'hFFFF_FFFF, 1'b0, 1'b0, 2'b10);
        look("R4 top base", 32'hFFFF_FFE0, 1'b0, 1'b0, 2'b10);
        look("R5 below top", 32'hFFFF_FFDF, 1'b0, 1'b1, 2'b10);

        // R7: external merge
        for (int e = 0; e < 4; e++) begin
            look("R7 NS region", 32'h0000_0180, 1'b0, 1'b0, e[1:0]);
            look("R7 NSC region", 32'h0000_00A0, 1'b0, 1'b1, e[1:0]);
            look("R7 S region", 32'h0000_0040, 1'b0, 1'b1, e[1:0]);
        end

        // R10: first-violation capture
        wr(3'd4, 32'h1, 1'b1);
        rd_chk("R10 cleared", 3'd4, 1'b1, 32'h0);
        look("R10 v1", 32'h0000_0044, 1'b0, 1'b0, 2'b10);
        look("R10 v2", 32'h0000_0028, 1'b0, 1'b1, 2'b10);
        rd_chk("R10 stat first", 3'd4, 1'b1, 32'h1);
        rd_chk("R10 addr first", 3'd5, 1'b1, 32'h0000_0044);
        wr(3'd4, 32'h1, 1'b0);
        rd_chk("R3 NS clear ignored", 3'd4, 1'b1, 32'h1);
        wr(3'd4, 32'h1, 1'b1);
        look("R10 v3", 32'h0000_0024, 1'b0, 1'b1, 2'b10);
        rd_chk("R10 stat fetch", 3'd4, 1'b1, 32'h3);
        rd_chk("R10 addr fetch", 3'd5, 1'b1, 32'h0000_0024);

        // R5: disabling one region at run time
        prog(1, 27'd10, 27'd20, 0, 0);
        look("R5 region off", 32'h0000_01E0, 1'b0, 1'b0, 2'b10);
        look("R4 overlap gone", 32'h0000_0240, 1'b0, 1'b0, 2'b10);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule